// File: doc/BRIEF.md
# Port Status LED Pattern Generator

This block turns the port state reported by a power-sourcing sequencer into the drive for one status LED (high = lit). A slow, even blink shows that the port is searching for a powered device. A steady light shows that power is applied. A fast, even blink shows an error. All timing is counted in millisecond ticks from a shared timebase, so the block needs no clock-frequency knowledge.

In the auto-restart error state the block also times the error display window. When that window ends, it raises a one-cycle done pulse for the sequencer and darkens the LED until the state changes. In the wait-for-disconnect state the fast blink runs with no time limit. Any change of the state code restarts the blink phase, so every new pattern begins with a full lit half-period.

Top module: `led_status_pattern`

## Requirements
- R1: While reset is asserted, and while the state code is 0 (inactive), `led_o` is 0 and `err_done_o` is 0.
- R2: For state code 1 (searching), the LED blinks with SLOW_HALF_MS ticks lit, then SLOW_HALF_MS ticks dark, and repeats (333 by default).
- R3: For state code 2 (powered), `led_o` is 1 continuously.
- R4: For state code 3 (error, auto-restart), the LED blinks with FAST_HALF_MS ticks lit and FAST_HALF_MS ticks dark (50 by default) until the error window ends.
- R5: In state code 3, on the ERR_WIN_MS-th tick after entering the state (2000 by default), `err_done_o` pulses high for exactly one cycle. From then on `led_o` stays 0 until the state code changes.
- R6: For state code 4 (waiting for disconnect), the fast blink of R4 continues indefinitely and `err_done_o` never rises.
- R7: On the clock edge where the state code changes, the blink phase restarts. A blinking state is lit in the cycle after that edge and stays lit for a full half-period of ticks. A tick that arrives on the change edge is not counted.
- R8: Blink phase and error window advance only on cycles with `ms_tick_i` high. Without ticks, `led_o` holds its value.
- R9: Unused state codes 5 to 7 behave as inactive: `led_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| state_i | input | 3 | Port state code: 0 inactive, 1 searching, 2 powered, 3 error, 4 waiting for disconnect |
| led_o | output | 1 | LED drive, 1 = lit |
| err_done_o | output | 1 | One-cycle pulse when the error display window ends |

## Verification
A wrong phase counter shows up at `led_o` as a lit or dark run that is one tick too long or too short. This becomes visible at the first toggle after a state change, within one half-period. A stale phase after a state change shows up in the very next cycle as a dark LED where a lit one is due. A faulty error window shows up as a missing, early, late or repeated `err_done_o` pulse around tick 2000, or as an LED that keeps blinking after the window ends. The bench therefore samples on exact tick boundaries on both sides of each toggle and of the window end.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SEARCH  = 3'd1,
    ST_POWERED = 3'd2,
    ST_FAULT   = 3'd3,
    ST_HOLD    = 3'd4
  } port_state_e;

  // blinking states take their half-period from the rate class
  function automatic logic is_blinking(input logic [2:0] code);
    return (code == ST_SEARCH) || (code == ST_FAULT) || (code == ST_HOLD);
  endfunction

  function automatic logic is_fast(input logic [2:0] code);
    return (code == ST_FAULT) || (code == ST_HOLD);
  endfunction

  // last count value of a half-period (count runs 0 .. half-1)
  function automatic int unsigned half_last(input logic [2:0] code,
                                            input int unsigned slow_half,
                                            input int unsigned fast_half);
    return (is_fast(code) ? fast_half : slow_half) - 1;
  endfunction

endpackage

// File: rtl/led_phase_timer.sv
module led_phase_timer #(
  parameter int unsigned SLOW_HALF = 333,
  parameter int unsigned FAST_HALF = 50,
  localparam int unsigned CW = $clog2(SLOW_HALF + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic [2:0] code_i,
  output logic       phase_o
);
  import led_status_pkg::*;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_w;
  logic          wrap_w;

  assign last_w = CW'(half_last(code_i, SLOW_HALF, FAST_HALF));
  assign wrap_w = tick_i && !restart_i && (cnt_q >= last_w);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || restart_i) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (tick_i) begin
      if (wrap_w) begin
        cnt_q   <= '0;
        phase_o <= ~phase_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_phase_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && is_blinking(code_i)) |-> (cnt_q <= last_w));

  assert_hold_no_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(phase_o));

endmodule

// File: rtl/led_err_window.sv
module led_err_window #(
  parameter int unsigned WIN_TICKS = 2000,
  localparam int unsigned WW = $clog2(WIN_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  input  logic active_i,
  output logic done_pulse_o,
  output logic expired_o
);
  logic [WW-1:0] win_q;
  logic          hit_w;

  assign hit_w = active_i && tick_i && !restart_i && !expired_o &&
                 (win_q == WW'(WIN_TICKS - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni || restart_i) begin
      win_q        <= '0;
      expired_o    <= 1'b0;
      done_pulse_o <= 1'b0;
    end else begin
      done_pulse_o <= hit_w;
      if (hit_w) expired_o <= 1'b1;
      if (active_i && tick_i && !expired_o && !hit_w) win_q <= win_q + 1'b1;
    end
  end

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_o |=> !done_pulse_o);

  assert_done_after_expiry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_o |-> expired_o);

endmodule

// File: rtl/led_status_pattern.sv
module led_status_pattern #(
  parameter int unsigned SLOW_HALF_MS = 333,
  parameter int unsigned FAST_HALF_MS = 50,
  parameter int unsigned ERR_WIN_MS   = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ms_tick_i,
  input  logic [2:0] state_i,
  output logic       led_o,
  output logic       err_done_o
);
  import led_status_pkg::*;

  logic [2:0] state_q;
  logic       state_change_w;
  logic       phase_w;
  logic       win_expired_w;
  logic       win_done_w;
  logic       in_fault_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_i;
  end

  assign state_change_w = (state_i != state_q);
  assign in_fault_w     = (state_q == ST_FAULT);

  led_phase_timer #(
    .SLOW_HALF(SLOW_HALF_MS),
    .FAST_HALF(FAST_HALF_MS)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (ms_tick_i),
    .restart_i(state_change_w),
    .code_i   (state_q),
    .phase_o  (phase_w)
  );

  led_err_window #(
    .WIN_TICKS(ERR_WIN_MS)
  ) u_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (ms_tick_i),
    .restart_i   (state_change_w),
    .active_i    (in_fault_w),
    .done_pulse_o(win_done_w),
    .expired_o   (win_expired_w)
  );

  always_comb begin
    unique case (state_q)
      ST_POWERED: led_o = 1'b1;
      ST_SEARCH,
      ST_HOLD:    led_o = phase_w;
      ST_FAULT:   led_o = phase_w && !win_expired_w;
      default:    led_o = 1'b0;
    endcase
  end

  assign err_done_o = win_done_w;

  assert_idle_dark_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd0 && !state_change_w) |=> !led_o);

  assert_powered_lit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd2) |=> led_o);

  assert_hold_no_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 3'd4) |-> !err_done_o);

  assert_restart_lit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_change_w && is_blinking(state_i)) |=> led_o);

  assert_unused_dark_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i >= 3'd5) |=> !led_o);

endmodule

// File: tb/led_status_pattern_test.sv
module led_status_pattern_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 333;
  localparam int FAST = 50;
  localparam int WIN  = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] st = 3'd0;
  logic       led, done;

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  bit finished = 0;

  led_status_pattern uut (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(tick), .state_i(st),
    .led_o(led), .err_done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) #1 if (done) done_seen++;

  // {state, tick, edges, expected led}
  typedef struct packed { logic [2:0] s; logic t; logic [15:0] n; logic l; } vec_t;
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 1'b1, 16'd1,    1'b1},  // R7 R2 lit right after change
    '{3'd1, 1'b1, 16'd332,  1'b1},  // R2 332 ticks counted, still lit
    '{3'd1, 1'b1, 16'd1,    1'b0},  // R2 333rd tick -> dark
    '{3'd1, 1'b1, 16'd332,  1'b0},  // R2 still dark
    '{3'd1, 1'b1, 16'd1,    1'b1},  // R2 lit again
    '{3'd1, 1'b0, 16'd900,  1'b1},  // R8 no ticks, holds
    '{3'd2, 1'b1, 16'd1,    1'b1},  // R3
    '{3'd2, 1'b1, 16'd700,  1'b1},  // R3
    '{3'd4, 1'b1, 16'd50,   1'b1},  // R6 49 ticks counted
    '{3'd4, 1'b1, 16'd1,    1'b0},  // R6 50th tick -> dark
    '{3'd4, 1'b1, 16'd50,   1'b1},  // R6 lit again
    '{3'd4, 1'b1, 16'd3000, 1'b1},  // R6 3100 ticks: 62 halves, lit
    '{3'd0, 1'b1, 16'd5,    1'b0},  // R1 inactive
    '{3'd5, 1'b1, 16'd3,    1'b0},  // R9
    '{3'd7, 1'b1, 16'd3,    1'b0},  // R9
    '{3'd1, 1'b1, 16'd1,    1'b1},  // R7 back to searching
    '{3'd0, 1'b1, 16'd1,    1'b0}   // R1
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(input logic [2:0] s, input logic t, input int n);
    st = s;
    tick = t;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset led", led, 1'b0);
    chk("R1 reset done", done, 1'b0);
    st = 3'd2;  // powered while in reset must stay dark
    repeat (3) @(negedge clk);
    chk("R1 reset holds led low", led, 1'b0);
    st = 3'd0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", led, 1'b0);

    for (int v = 0; v < NV; v++) begin
      run(VEC[v].s, VEC[v].t, int'(VEC[v].n));
      chk($sformatf("R2/R3/R6/R7/R8/R9 vector %0d", v), led, VEC[v].l);
    end
    chk("R6 no done pulse in hold", done_seen != 0, 1'b0);

    // R4 / R5 error window
    done_seen = 0;
    run(3'd3, 1'b1, 1);
    chk("R4 fault lit at entry", led, 1'b1);
    run(3'd3, 1'b1, 49);
    chk("R4 fault lit before 50th tick", led, 1'b1);
    run(3'd3, 1'b1, 1);
    chk("R4 fault dark after 50th tick", led, 1'b0);
    run(3'd3, 1'b1, 1949);       // 2000 edges, 1999 ticks
    chk("R5 no done before window", done, 1'b0);
    run(3'd3, 1'b1, 1);          // 2000th tick
    chk("R5 done pulse", done, 1'b1);
    chk("R5 led dark at window end", led, 1'b0);
    run(3'd3, 1'b1, 1);
    chk("R5 done one cycle", done, 1'b0);
    run(3'd3, 1'b1, 120);        // would be lit if still blinking
    chk("R5 led stays dark", led, 1'b0);
    chk("R5 exactly one pulse", done_seen == 1, 1'b1);
    run(3'd1, 1'b1, 1);
    chk("R7 searching resumes lit", led, 1'b1);

    // R7 restart from a dark phase
    run(3'd1, 1'b1, 340);
    chk("R2 dark phase", led, 1'b0);
    run(3'd4, 1'b1, 1);
    chk("R7 change relights", led, 1'b1);
    run(3'd4, 1'b0, 20);
    chk("R8 hold without ticks", led, 1'b1);

    // reset mid-run
    st = 3'd2;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", led, 1'b0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule